// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven by a single control write port. Each write carries a run flag and a 3-bit key. Software arms the watchdog and then services it at intervals. To service it or halt it, software must present the bitwise complement of the key it wrote last, so a stray write alone cannot keep the timer quiet.

Once the watchdog is armed, if no valid service arrives within a first, long window, it raises a non-maskable interrupt request. That gives software a last chance to save state. If a second, shorter window then also runs out without a service, the block emits a single-cycle chip reset pulse and falls back to the halted state. Both windows are parameters counted in clock cycles.

A write whose key is not the complement of the stored key is not a service. It only replaces the stored key, and the running countdown continues undisturbed.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is halted, with `nmi_o` and `chip_rst_o` both low.
- R2: While halted, a write with `wr_run`=1 arms the watchdog and stores `wr_key`. `nmi_o` rises exactly `NMI_CYCLES` clock edges after the edge that captured the write.
- R3: While halted, a write with `wr_run`=0 has no effect: no interrupt and no reset follow.
- R4: While armed, a write with `wr_run`=0 and `wr_key` equal to the bitwise complement of the stored key halts the watchdog. `nmi_o` drops at the next edge if it was high, and no later event occurs.
- R5: While armed, a write with `wr_run`=1 and `wr_key` equal to the complement of the stored key restarts the first window from zero, and `wr_key` becomes the stored key.
- R6: While armed, a write whose `wr_key` is not the complement of the stored key replaces the stored key with `wr_key` and does not disturb the countdown. The next valid service must use the complement of this new key.
- R7: `nmi_o` stays high until a valid service, a valid halt, or expiry of the second window.
- R8: If the watchdog is not serviced within `RESET_CYCLES` edges after `nmi_o` rises, then at that edge `chip_rst_o` pulses high for exactly one cycle, `nmi_o` falls, and the watchdog is halted.
- R9: A valid service while `nmi_o` is high clears `nmi_o` at the next edge and starts a full first window again. A service that arrives at the same edge as an expiry takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_run | input | 1 | Run flag of the write |
| wr_key | input | KEY_W | Key field of the write |
| nmi_o | output | 1 | Non-maskable interrupt request, level |
| chip_rst_o | output | 1 | Chip reset request, one-cycle pulse |

## Verification
The assertions assume that `wr_en` is a one-cycle strobe with `wr_run` and `wr_key` stable in that cycle. They also assume that writes arrive only once the internal reset has been released. The stimulus therefore waits several cycles after reset and drives each write for exactly one clock. It places services and halts a known number of cycles before each window expires, and puts one service inside the interrupt window. This lets every interrupt and reset edge be predicted to the exact cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_ALERT = 2'd2
  } wd_state_e;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_SERVICE = 3'd2,
    CMD_HALT    = 3'd3,
    CMD_REKEY   = 3'd4
  } wd_cmd_e;

endpackage

// File: rtl/wdg_key_guard.sv
module wdg_key_guard
  import wdg_pkg::*;
#(
  parameter int KEY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_run,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             running,
  output wd_cmd_e          cmd
);

  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] key_d;
  logic             key_en;
  logic             key_match;

  assign key_match = (wr_key == ~key_q);

  always_comb begin
    cmd    = CMD_NONE;
    key_d  = key_q;
    key_en = 1'b0;
    if (wr_en) begin
      if (!running) begin
        if (wr_run) begin
          cmd    = CMD_START;
          key_d  = wr_key;
          key_en = 1'b1;
        end
      end else begin
        key_d  = wr_key;
        key_en = 1'b1;
        if (key_match) begin
          cmd = wr_run ? CMD_SERVICE : CMD_HALT;
        end else begin
          cmd = CMD_REKEY;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (key_en) begin
      key_q <= key_d;
    end
  end

  // R6: a rejected key is stored, so servicing next cycle needs its complement
  assert_rekey_stores_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REKEY) |=> (key_q == $past(wr_key)));

endmodule

// File: rtl/wdg_stage_timer.sv
module wdg_stage_timer
  import wdg_pkg::*;
#(
  parameter int FIRST_CYCLES  = 16,
  parameter int SECOND_CYCLES = 4,
  parameter int CNT_W         = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  wd_cmd_e cmd,
  output logic    running,
  output logic    nmi,
  output logic    chip_rst
);

  localparam logic [CNT_W-1:0] FIRST_LAST  = CNT_W'(FIRST_CYCLES - 1);
  localparam logic [CNT_W-1:0] SECOND_LAST = CNT_W'(SECOND_CYCLES - 1);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             rst_q, rst_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rst_d   = 1'b0;
    unique case (state_q)
      WD_IDLE: begin
        if (cmd == CMD_START) begin
          state_d = WD_ARMED;
          cnt_d   = '0;
        end
      end
      WD_ARMED, WD_ALERT: begin
        if (cmd == CMD_HALT) begin
          state_d = WD_IDLE;
          cnt_d   = '0;
        end else if (cmd == CMD_SERVICE) begin
          state_d = WD_ARMED;
          cnt_d   = '0;
        end else if (state_q == WD_ARMED) begin
          if (cnt_q == FIRST_LAST) begin
            state_d = WD_ALERT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == SECOND_LAST) begin
            state_d = WD_IDLE;
            cnt_d   = '0;
            rst_d   = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = WD_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign cnt_en = (state_q != WD_IDLE) || (cmd == CMD_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign running  = (state_q != WD_IDLE);
  assign nmi      = (state_q == WD_ALERT);
  assign chip_rst = rst_q;

  // R2: the first window never runs past its limit
  assert_armed_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_ARMED) |-> (cnt_q <= FIRST_LAST));

  // R8: the second window never runs past its limit
  assert_alert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_ALERT) |-> (cnt_q <= SECOND_LAST));

  // R8: reset request lasts one cycle
  assert_reset_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !chip_rst);

  // R8: reset only after an interrupt stage, and leaves the block halted
  assert_reset_after_alert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> ($past(nmi) && !running));

  // R4: a valid halt stops the watchdog
  assert_halt_idles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HALT) |=> (!running && !nmi));

  // R9: a valid service clears the interrupt and keeps counting
  assert_service_clears_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SERVICE) |=> (running && !nmi && !chip_rst));

  // R2: an accepted start arms without an interrupt
  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_START) |=> (running && !nmi));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int KEY_W        = 3,
  parameter int NMI_CYCLES   = 5000000,
  parameter int RESET_CYCLES = 165000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_run,
  input  logic [KEY_W-1:0] wr_key,
  output logic             nmi_o,
  output logic             chip_rst_o
);

  localparam int MAX_WIN = (NMI_CYCLES > RESET_CYCLES) ? NMI_CYCLES : RESET_CYCLES;
  localparam int CNT_W   = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       running;
  wd_cmd_e    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_s = rst_sync_q[1];

  wdg_key_guard #(
    .KEY_W (KEY_W)
  ) u_guard (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_run  (wr_run),
    .wr_key  (wr_key),
    .running (running),
    .cmd     (cmd)
  );

  wdg_stage_timer #(
    .FIRST_CYCLES  (NMI_CYCLES),
    .SECOND_CYCLES (RESET_CYCLES),
    .CNT_W         (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cmd      (cmd),
    .running  (running),
    .nmi      (nmi_o),
    .chip_rst (chip_rst_o)
  );

  // R3: a write with the run flag low leaves a halted watchdog halted
  assert_idle_clear_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!running && wr_en && !wr_run) |=> !running);

  // R1: nothing is requested while halted
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!running && !$past(running)) |-> (!nmi_o && !chip_rst_o));

endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int KW         = 3;
  localparam int N          = 12;
  localparam int R          = 5;

  localparam int EV_NMI_UP = 0;
  localparam int EV_NMI_DN = 1;
  localparam int EV_RST_UP = 2;
  localparam int EV_RST_DN = 3;

  typedef struct {
    int    cyc;
    int    kind;
    string req;
  } ev_t;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic          wr_run;
  logic [KW-1:0] wr_key;
  logic          nmi_o;
  logic          chip_rst_o;

  int  cyc;
  int  checks;
  int  errors;
  bit  mon_on;
  bit  done;
  logic nmi_prev;
  logic rst_prev;
  ev_t exp_q[$];

  keyed_watchdog #(
    .KEY_W        (KW),
    .NMI_CYCLES   (N),
    .RESET_CYCLES (R)
  ) u_keyed_watchdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_run     (wr_run),
    .wr_key     (wr_key),
    .nmi_o      (nmi_o),
    .chip_rst_o (chip_rst_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(input int kind, input int at, input string req);
    ev_t e;
    e.cyc = at; e.kind = kind; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int kind);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R3/R4/R6 unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == kind, e.req, kind, e.kind);
      check(e.cyc == cyc, e.req, cyc, e.cyc);
    end
  endtask

  // monitor: compares every output edge with the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (nmi_o !== nmi_prev) observe(nmi_o ? EV_NMI_UP : EV_NMI_DN);
      if (chip_rst_o !== rst_prev) observe(chip_rst_o ? EV_RST_UP : EV_RST_DN);
      nmi_prev = nmi_o;
      rst_prev = chip_rst_o;
    end
  end

  // drives one write; its capture edge is two cycles on from the call
  task automatic write_ctl(input logic run, input logic [KW-1:0] key);
    @(negedge clk);
    wr_en = 1'b1; wr_run = run; wr_key = key;
    @(negedge clk);
    wr_en = 1'b0; wr_run = 1'b0; wr_key = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w;
    int w2;
    int w3;
    checks = 0; errors = 0; mon_on = 1'b0; done = 1'b0;
    nmi_prev = 1'b0; rst_prev = 1'b0;
    wr_en = 1'b0; wr_run = 1'b0; wr_key = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(5);
    // R1: reset state
    check(nmi_o == 1'b0, "R1 nmi after reset", nmi_o, 0);
    check(chip_rst_o == 1'b0, "R1 chip_rst after reset", chip_rst_o, 0);
    mon_on = 1'b1;
    idle(3 * N);

    // R3: clear-write while halted does nothing
    write_ctl(1'b0, 3'd2);
    idle(3 * N);
    check(nmi_o == 1'b0, "R3 no interrupt after halted clear write", nmi_o, 0);

    // R2, R7, R8: start and let both windows expire
    w = cyc + 2;
    push(EV_NMI_UP, w + N, "R2 interrupt after first window");
    push(EV_NMI_DN, w + N + R, "R7 interrupt held until expiry");
    push(EV_RST_UP, w + N + R, "R8 reset after second window");
    push(EV_RST_DN, w + N + R + 1, "R8 reset is one cycle");
    write_ctl(1'b1, 3'd3);
    idle(N + R + 3 * N);

    // R5, R4: service before expiry, then halt with the complement of the new key
    w = cyc + 2;
    write_ctl(1'b1, 3'd1);
    wait_until(w + N - 5);
    w2 = cyc + 2;
    write_ctl(1'b1, 3'd6);
    wait_until(w2 + N - 5);
    write_ctl(1'b0, 3'd1);
    idle(3 * N);
    check(nmi_o == 1'b0, "R4 halted after valid halt write", nmi_o, 0);

    // R6, R9, R4: rejected key, service in the interrupt stage, halt in it
    w = cyc + 2;
    push(EV_NMI_UP, w + N, "R6 rejected key leaves countdown running");
    write_ctl(1'b1, 3'd4);
    idle(2);
    write_ctl(1'b0, 3'd2);
    wait_until(w + N + 1);
    w2 = cyc + 2;
    push(EV_NMI_DN, w2, "R9 service clears interrupt");
    push(EV_NMI_UP, w2 + N, "R9 full window after service");
    write_ctl(1'b1, 3'd5);
    wait_until(w2 + N + 1);
    w3 = cyc + 2;
    push(EV_NMI_DN, w3, "R4 halt during interrupt stage");
    write_ctl(1'b0, 3'd2);
    idle(N + R + 2 * N);

    check(exp_q.size() == 0, "R2/R8 all expected events seen", exp_q.size(), 0);
    finish_run();
  end

endmodule